// File: doc/BRIEF.md
# Interleaved System-to-Channel Address Decoder

This block maps a system physical address onto one of four memory channels and gives the address local to that channel. The four channels are two slices with two channels each. The mapping first checks that the address is DRAM at all. It then closes the I/O hole that sits below 4 GB and works out which region the address belongs to. Each region has its own rule for picking the channel.

The region rules are as follows.
- Two single-channel asymmetric regions each send their whole range to one fixed channel.
- A two-way asymmetric region splits its range between the two channels of one slice.
- Every other address is spread over the slices and channels that are enabled. Each selection is the parity of the address bits picked by a mask.
- An override window can replace the parity hashes with fixed address bits.

After the selection, the selector bits are removed from the address, so each channel sees a dense address space.

All configuration is static and comes in on input pins: the memory tops, the region bounds, the hash masks and the mode flags. One address is accepted per cycle. The result appears on registered outputs one cycle later.

Top module: `sys_chan_decoder`

## Requirements
- R1: An address is flagged `out_err` in any of three cases: it is at or above 2^39, it lies in [`low_top`, 4 GB), or it is at or above `high_top`. A flagged result has `out_chan` = 0 and `out_addr` = 0.
- R2: Below 4 GB the contiguous address equals the system address. At or above 4 GB, (4 GB − `low_top`) is subtracted from it.
- R3: `out_chan` bit 1 is the slice and bit 0 is the channel. In normal selector mode the base selector position is 10, 11, 12 or 12 for `il_mode` 0, 1, 2 or 3. The slice selector uses the base position. The channel selector uses the base position plus one when both slices and channels interleave, and the base position otherwise.
- R4: With `hi_sel_mode` set, the slice selector is bit 29. The channel selector is bit 30 when both dimensions interleave, and bit 29 otherwise. The configured hash masks are then ignored.
- R5: Each selection bit is the XOR of the masked bits. The slice hash works on the system address and the channel hash works on the contiguous address. Each configured hash mask is placed starting at address bit 6. When only one dimension interleaves, its selector bit is also added to its mask.
- R6: Inside the enabled override window, outside the single-channel regions, address bit 12 gives the slice. Address bit 13 gives the channel when two slices interleave, and bit 12 otherwise. These bits are also the ones removed.
- R7: Removing bit k keeps the bits below k and shifts the bits above k down by one. The channel selector bit is removed first and the slice selector bit second.
- R8: In a single-channel region, region 0 gives `out_chan` = {0, `a0_chan`} and region 1 gives {1, `a1_chan`}. The local address is the offset from the region's contiguous base. When that channel also holds symmetric memory (`sym_map` bit = `out_chan`) and `sym_map` is nonzero, the base shifted right by (popcount(`sym_map`) >> 1) is added.
- R9: In the two-way region, `out_chan` is {`a2_slice`, channel hash}. The selector bit is removed from the offset within the region, and the base shifted right by (popcount(`sym_map`) >> 1) is added.
- R10: When regions overlap, region 0 wins over region 1, region 1 over the two-way region, and the two-way region over symmetric interleave.
- R11: `out_valid` follows `in_valid` one cycle later. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address is presented |
| sys_addr | input | ADDR_W | System physical address |
| low_top | input | ADDR_W | Top of low DRAM (start of the hole) |
| high_top | input | ADDR_W | Top of DRAM above 4 GB |
| slice_il | input | 1 | Two slices interleave |
| chan_il | input | 1 | Two channels per slice interleave |
| hi_sel_mode | input | 1 | Selectors fixed at bits 29/30 |
| il_mode | input | 2 | Base selector position code |
| slice_hash_cfg | input | HASH_W | Slice hash mask, placed from bit 6 |
| chan_hash_cfg | input | HASH_W | Channel hash mask, placed from bit 6 |
| sym_map | input | 4 | Channels holding symmetric memory |
| a0_en | input | 1 | Region 0 enable |
| a0_base | input | ADDR_W | Region 0 first address |
| a0_limit | input | ADDR_W | Region 0 last address |
| a0_chan | input | 1 | Region 0 channel within slice 0 |
| a1_en | input | 1 | Region 1 enable |
| a1_base | input | ADDR_W | Region 1 first address |
| a1_limit | input | ADDR_W | Region 1 last address |
| a1_chan | input | 1 | Region 1 channel within slice 1 |
| a2_en | input | 1 | Two-way region enable |
| a2_base | input | ADDR_W | Two-way region first address |
| a2_limit | input | ADDR_W | Two-way region last address |
| a2_slice | input | 1 | Slice used by the two-way region |
| ovr_en | input | 1 | Override window enable |
| ovr_base | input | ADDR_W | Override window first address |
| ovr_limit | input | ADDR_W | Override window last address |
| out_valid | output | 1 | Result valid |
| out_err | output | 1 | Address is not DRAM |
| out_chan | output | 2 | {slice, channel} |
| out_addr | output | ADDR_W | Channel-local address |

## Verification
A vector table runs with both dimensions interleaved and one-bit hash masks. It covers addresses with each combination of selector bits, addresses above the hole, and addresses at each rejection edge, which separates hole removal from bit squeezing. Directed cases then cover five further situations:
- A two-bit channel mask, to tell parity from a single bit.
- A single-dimension setup, where only the selector bit forms the mask.
- The high selector mode with bits 29 and 30 both set, where only channel-first removal gives the expected address.
- Override-window addresses whose fixed bits disagree with the hashes.
- Each asymmetric region with and without symmetric memory on its channel, including one overlap that exposes the region priority.

// File: rtl/sys_chan_decoder.sv
module sys_chan_decoder #(
  parameter int ADDR_W    = 40,
  parameter int PHYS_BITS = 39,
  parameter int HASH_W    = 14,
  parameter int HASH_LSB  = 6,
  parameter int OVR_BIT   = 12,
  parameter int HI_SEL    = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] sys_addr,
  input  logic [ADDR_W-1:0] low_top,
  input  logic [ADDR_W-1:0] high_top,
  input  logic              slice_il,
  input  logic              chan_il,
  input  logic              hi_sel_mode,
  input  logic [1:0]        il_mode,
  input  logic [HASH_W-1:0] slice_hash_cfg,
  input  logic [HASH_W-1:0] chan_hash_cfg,
  input  logic [3:0]        sym_map,
  input  logic              a0_en,
  input  logic [ADDR_W-1:0] a0_base,
  input  logic [ADDR_W-1:0] a0_limit,
  input  logic              a0_chan,
  input  logic              a1_en,
  input  logic [ADDR_W-1:0] a1_base,
  input  logic [ADDR_W-1:0] a1_limit,
  input  logic              a1_chan,
  input  logic              a2_en,
  input  logic [ADDR_W-1:0] a2_base,
  input  logic [ADDR_W-1:0] a2_limit,
  input  logic              a2_slice,
  input  logic              ovr_en,
  input  logic [ADDR_W-1:0] ovr_base,
  input  logic [ADDR_W-1:0] ovr_limit,
  output logic              out_valid,
  output logic              out_err,
  output logic [1:0]        out_chan,
  output logic [ADDR_W-1:0] out_addr
);

  localparam logic [ADDR_W-1:0] FOUR_G   = ADDR_W'(64'h1_0000_0000);
  localparam logic [ADDR_W-1:0] PHYS_LIM = ADDR_W'(1) << PHYS_BITS;
  localparam logic [5:0]        OVR_POS  = 6'(OVR_BIT);
  localparam logic [5:0]        HI_POS   = 6'(HI_SEL);

  function automatic logic [ADDR_W-1:0] drop_bit(input logic [ADDR_W-1:0] v,
                                                 input logic en, input logic [5:0] k);
    logic [ADDR_W-1:0] low_m;
    low_m = (ADDR_W'(1) << k) - ADDR_W'(1);
    return en ? (((v >> 1) & ~low_m) | (v & low_m)) : v;
  endfunction

  logic [ADDR_W-1:0] gap, contig;
  logic              bad;
  assign gap    = FOUR_G - low_top;
  assign contig = (sys_addr < FOUR_G) ? sys_addr : sys_addr - gap;
  assign bad    = (sys_addr >= PHYS_LIM) || (sys_addr >= low_top && sys_addr < FOUR_G)
                  || (sys_addr >= high_top);

  function automatic logic [ADDR_W-1:0] to_contig(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] g);
    return (a < FOUR_G) ? a : a - g;
  endfunction

  logic [5:0] base_pos, s_pos, c_pos;
  always_comb begin
    case (il_mode)
      2'd0:    base_pos = 6'd10;
      2'd1:    base_pos = 6'd11;
      default: base_pos = 6'd12;
    endcase
  end
  assign s_pos = hi_sel_mode ? HI_POS : base_pos;
  assign c_pos = (hi_sel_mode ? HI_POS : base_pos) + {5'd0, slice_il};

  logic [ADDR_W-1:0] s_mask, c_mask;
  assign s_mask = (hi_sel_mode ? '0 : (ADDR_W'(slice_hash_cfg) << HASH_LSB))
                | ((slice_il && !chan_il) ? (ADDR_W'(1) << s_pos) : '0);
  assign c_mask = (hi_sel_mode ? '0 : (ADDR_W'(chan_hash_cfg) << HASH_LSB))
                | ((chan_il && !slice_il) ? (ADDR_W'(1) << c_pos) : '0);

  logic in_a0, in_a1, in_a2, in_ovr;
  assign in_a0  = a0_en  && sys_addr >= a0_base  && sys_addr <= a0_limit;
  assign in_a1  = a1_en  && sys_addr >= a1_base  && sys_addr <= a1_limit;
  assign in_a2  = a2_en  && sys_addr >= a2_base  && sys_addr <= a2_limit;
  assign in_ovr = ovr_en && sys_addr >= ovr_base && sys_addr <= ovr_limit;

  logic [2:0] sym_cnt;
  logic [1:0] sym_sh;
  assign sym_cnt = 3'(sym_map[0]) + 3'(sym_map[1]) + 3'(sym_map[2]) + 3'(sym_map[3]);
  assign sym_sh  = sym_cnt[2:1];

  logic [1:0]        nx_chan;
  logic [ADDR_W-1:0] nx_addr, rbase;
  logic              s_bit, c_bit, s_rm, c_rm;
  logic [5:0]        s_rm_pos, c_rm_pos;
  always_comb begin
    nx_chan  = '0;
    nx_addr  = '0;
    rbase    = '0;
    s_bit    = 1'b0;
    c_bit    = 1'b0;
    s_rm     = 1'b0;
    c_rm     = 1'b0;
    s_rm_pos = s_pos;
    c_rm_pos = c_pos;
    if (in_a0) begin
      nx_chan = {1'b0, a0_chan};
      rbase   = to_contig(a0_base, gap);
      nx_addr = contig - rbase + ((sym_cnt != 0 && sym_map[nx_chan]) ? (rbase >> sym_sh) : '0);
    end else if (in_a1) begin
      nx_chan = {1'b1, a1_chan};
      rbase   = to_contig(a1_base, gap);
      nx_addr = contig - rbase + ((sym_cnt != 0 && sym_map[nx_chan]) ? (rbase >> sym_sh) : '0);
    end else if (in_a2) begin
      c_bit    = in_ovr ? sys_addr[OVR_BIT] : ^(contig & c_mask);
      c_rm     = in_ovr || chan_il;
      c_rm_pos = in_ovr ? OVR_POS : c_pos;
      nx_chan  = {a2_slice, c_bit};
      rbase    = to_contig(a2_base, gap);
      nx_addr  = (rbase >> sym_sh) + drop_bit(contig - rbase, c_rm, c_rm_pos);
    end else begin
      if (slice_il) begin
        s_rm     = 1'b1;
        s_rm_pos = in_ovr ? OVR_POS : s_pos;
        s_bit    = in_ovr ? sys_addr[OVR_BIT] : ^(sys_addr & s_mask);
      end
      if (chan_il) begin
        c_rm     = 1'b1;
        c_rm_pos = in_ovr ? (OVR_POS + {5'd0, slice_il}) : c_pos;
        c_bit    = in_ovr ? sys_addr[c_rm_pos] : ^(contig & c_mask);
      end
      nx_chan = {s_bit, c_bit};
      nx_addr = drop_bit(drop_bit(contig, c_rm, c_rm_pos), s_rm, s_rm_pos);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_chan  <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid && bad;
      out_chan  <= (in_valid && !bad) ? nx_chan : '0;
      out_addr  <= (in_valid && !bad) ? nx_addr : '0;
    end
  end

  assert_err_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_chan == 2'b00 && out_addr == '0));

  assert_phys_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sys_addr >= PHYS_LIM) |=> out_err);

  assert_hole_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sys_addr >= low_top && sys_addr < FOUR_G) |=> out_err);

  assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_err_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_err);

endmodule

// File: tb/sys_chan_decoder_test.sv
`timescale 1ns/1ps
module sys_chan_decoder_test;
  localparam int AW = 40;
  localparam int HW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic in_valid;
  logic [AW-1:0] sys_addr, low_top, high_top;
  logic slice_il, chan_il, hi_sel_mode;
  logic [1:0] il_mode;
  logic [HW-1:0] slice_hash_cfg, chan_hash_cfg;
  logic [3:0] sym_map;
  logic a0_en, a0_chan, a1_en, a1_chan, a2_en, a2_slice, ovr_en;
  logic [AW-1:0] a0_base, a0_limit, a1_base, a1_limit, a2_base, a2_limit, ovr_base, ovr_limit;
  logic out_valid, out_err;
  logic [1:0] out_chan;
  logic [AW-1:0] out_addr;

  sys_chan_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sys_addr(sys_addr),
    .low_top(low_top), .high_top(high_top), .slice_il(slice_il), .chan_il(chan_il),
    .hi_sel_mode(hi_sel_mode), .il_mode(il_mode), .slice_hash_cfg(slice_hash_cfg),
    .chan_hash_cfg(chan_hash_cfg), .sym_map(sym_map),
    .a0_en(a0_en), .a0_base(a0_base), .a0_limit(a0_limit), .a0_chan(a0_chan),
    .a1_en(a1_en), .a1_base(a1_base), .a1_limit(a1_limit), .a1_chan(a1_chan),
    .a2_en(a2_en), .a2_base(a2_base), .a2_limit(a2_limit), .a2_slice(a2_slice),
    .ovr_en(ovr_en), .ovr_base(ovr_base), .ovr_limit(ovr_limit),
    .out_valid(out_valid), .out_err(out_err), .out_chan(out_chan), .out_addr(out_addr));

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  localparam int NV = 7;
  localparam logic [AW-1:0] V_ADDR [NV] = '{40'h00_0000_0C00, 40'h00_1234_5678, 40'h01_0000_0800,
    40'h00_8000_0000, 40'h01_8000_0000, 40'h00_7FFF_FFFF, 40'h01_0000_0000};
  localparam logic V_ERR [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [1:0] V_CHAN [NV] = '{2'd3, 2'd2, 2'd1, 2'd0, 2'd0, 2'd3, 2'd0};
  localparam logic [AW-1:0] V_LOC [NV] = '{40'h0, 40'h00_048D_1678, 40'h00_2000_0000,
    40'h0, 40'h0, 40'h00_1FFF_FFFF, 40'h00_2000_0000};

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  task automatic check(string req, logic [AW+2:0] act, logic [AW+2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got err=%0d chan=%0d addr=%h, expected err=%0d chan=%0d addr=%h",
               req, act[AW+2], act[AW+1:AW], act[AW-1:0], exp[AW+2], exp[AW+1:AW], exp[AW-1:0]);
    end
  endtask

  task automatic cfg_default();
    low_top = 40'h00_8000_0000; high_top = 40'h01_8000_0000;
    slice_il = 1'b1; chan_il = 1'b1; hi_sel_mode = 1'b0; il_mode = 2'd0;
    slice_hash_cfg = 14'h10; chan_hash_cfg = 14'h20; sym_map = 4'hF;
    a0_en = 0; a0_base = 0; a0_limit = 0; a0_chan = 0;
    a1_en = 0; a1_base = 0; a1_limit = 0; a1_chan = 0;
    a2_en = 0; a2_base = 0; a2_limit = 0; a2_slice = 0;
    ovr_en = 0; ovr_base = 0; ovr_limit = 0;
  endtask

  task automatic run(string req, logic [AW-1:0] a, logic e, logic [1:0] ch, logic [AW-1:0] loc);
    @(negedge clk);
    sys_addr = a;
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    n_checks++;
    if (out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R11: out_valid=%0d expected 1", out_valid);
    end
    check(req, {out_err, out_chan, out_addr}, {e, ch, loc});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    in_valid = 1'b0;
    sys_addr = '0;
    cfg_default();
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 reset: out_valid=%0d expected 0", out_valid);
    end
    check("R11 reset", {out_err, out_chan, out_addr}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run("R1 R2 R3 R5 R7 table", V_ADDR[i], V_ERR[i], V_CHAN[i], V_LOC[i]);

    // R5: two-bit channel mask (bits 6 and 11) gives parity 0
    chan_hash_cfg = 14'h21;
    run("R5 parity", 40'h840, 1'b0, 2'd0, 40'h40);
    cfg_default();

    // R3 R5: channel only, il_mode 2 -> selector bit 12 joins the mask
    slice_il = 1'b0; il_mode = 2'd2; chan_hash_cfg = 14'h0;
    run("R3 single dim", 40'h3000, 1'b0, 2'd1, 40'h1000);
    cfg_default();

    // R4: slice only, high mode -> bit 29
    chan_il = 1'b0; hi_sel_mode = 1'b1;
    run("R4 high slice", 40'h2000_0010, 1'b0, 2'd2, 40'h10);
    // R4 R7: both dims, bits 30 then 29 removed, configured masks ignored
    chan_il = 1'b1;
    run("R7 order", 40'h6000_1234, 1'b0, 2'd0, 40'h1234);
    cfg_default();

    // R6: override window, channel from bit 13
    ovr_en = 1'b1; ovr_limit = 40'h00FF_FFFF;
    run("R6 override", 40'h2000, 1'b0, 2'd1, 40'h0);
    cfg_default();

    // R8: region 0, channel 1 holds symmetric memory
    a0_en = 1; a0_base = 40'h01_0000_0000; a0_limit = 40'h01_3FFF_FFFF; a0_chan = 1;
    run("R8 region0 sym", 40'h01_0000_1000, 1'b0, 2'd1, 40'h00_2000_1000);
    sym_map = 4'b1101;
    run("R8 region0 nosym", 40'h01_0000_1000, 1'b0, 2'd1, 40'h1000);
    sym_map = 4'hF;
    // R10: region 0 beats overlapping two-way region
    a2_en = 1; a2_base = 40'h01_0000_0000; a2_limit = 40'h01_3FFF_FFFF; a2_slice = 1;
    run("R10 priority", 40'h01_0000_1000, 1'b0, 2'd1, 40'h00_2000_1000);
    a0_en = 0;
    // R9: two-way region, channel hash on contig bit 11
    run("R9 two-way", 40'h01_0000_0800, 1'b0, 2'd3, 40'h00_2000_0000);
    cfg_default();

    // R8: region 1, channel 0 -> index 2
    a1_en = 1; a1_base = 40'h01_4000_0000; a1_limit = 40'h01_7FFF_FFFF; a1_chan = 0;
    run("R8 region1", 40'h01_4000_0020, 1'b0, 2'd2, 40'h00_3000_0020);
    cfg_default();

    // R1: 2^39 boundary with high top out of the way
    high_top = 40'hFF_FFFF_FFFF;
    run("R1 phys limit", 40'h80_0000_0000, 1'b1, 2'd0, 40'h0);
    run("R1 below limit", 40'h7F_FFFF_F000, 1'b0, 2'd0, 40'h1F_DFFF_FC00);

    finish_run();
  end
endmodule